// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits behind an eight-byte I/O window and turns it into indirect access to configuration space. The lower four bytes form a 32-bit address latch that software loads one, two or four bytes at a time. The upper four bytes are a data window. When the latch's top bit is set, a read or write through the window is passed to a downstream configuration port. The fields the port needs (bus, device, function, dword register) are cut from the latch.

The host side is a simple strobe bus. One request cycle carries a byte offset, a byte length of 1 to 4, and write data aligned to the low byte lanes. Every read gets exactly one response pulse, with the returned bytes aligned to the low lanes. Writes get no response. The host issues a new read only after the previous response has arrived. A one-byte write at offset 1 with bit 2 set is not a latch update. It raises a one-cycle reset request toward the system.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the latch reads 0, so the data window is disabled, and host_rvalid, rst_req and cfg_req are all low.
- R2: Offsets 0-3 select the latch and offsets 4-7 select the data window. A read at offset 8 or above answers locally from the value 0xFFFFFFFF. A write at offset 8 or above changes nothing and raises no output.
- R3: A latch write of length 1, 2 or 4 with offset plus length at most 4 replaces only lanes offset to offset+length-1 of the latch. The new bytes are taken from host_wdata starting at its lowest byte.
- R4: A latch write of any other length, or with offset plus length above 4, leaves the latch unchanged.
- R5: A one-byte write at offset 1 with host_wdata bit 2 set pulses rst_req high for exactly one cycle, starting the cycle after the request, and leaves the latch unchanged. This check takes priority over the latch write.
- R6: While latch bit 31 is 0, data-window reads answer from the value 0xFFFFFFFF and data-window writes raise no cfg_req.
- R7: A read with start lane s = offset mod 4 and length n, where s+n is at most 4, returns byte i (for i below n) equal to bits [(s+i)*8 +: 8] of the selected value. Bytes at and above n are 0.
- R8: A read with s+n above 4 returns 0xFFFFFFFF and sends nothing downstream.
- R9: A forwarded access drives cfg_bus from latch bits 23:16, cfg_dev from bits 15:11 and cfg_fn from bits 10:8. It drives cfg_reg, the dword index, from bits 7:2 of the 8-bit register field.
- R10: An enabled data-window write raises cfg_req with cfg_we=1. cfg_boff carries the offset minus 4, and cfg_len and cfg_wdata are passed through unchanged.
- R11: A local read response appears the cycle after the request. A forwarded read raises cfg_req the cycle after the request, and its response appears the cycle after cfg_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 for write, 0 for read |
| host_off | input | OFF_W | Byte offset in the window |
| host_len | input | 3 | Access length in bytes |
| host_wdata | input | 32 | Write data, low-lane aligned |
| host_rvalid | output | 1 | Read response strobe |
| host_rdata | output | 32 | Read data, low-lane aligned |
| rst_req | output | 1 | One-cycle system reset request |
| cfg_req | output | 1 | Downstream access strobe |
| cfg_we | output | 1 | Downstream write flag |
| cfg_bus | output | BUS_W | Decoded bus number |
| cfg_dev | output | DEV_W | Decoded device number |
| cfg_fn | output | FN_W | Decoded function number |
| cfg_reg | output | REG_W-2 | Decoded dword register index |
| cfg_boff | output | 2 | Byte offset within the dword |
| cfg_len | output | 3 | Byte length |
| cfg_wdata | output | 32 | Write data passed downstream |
| cfg_rvalid | input | 1 | Downstream read response strobe |
| cfg_rdata | input | 32 | Downstream read data |

## Verification
The hardest case to reach is the forwarded read. Its response timing depends on a downstream answer arriving a cycle later, and its lane shaping must use the start lane and length saved at request time, not the live host inputs. The bench reaches this case in three steps. First it sets the enable bit through a full latch write. It then drives reads at several window offsets against a reactive downstream model, whose data encodes the decoded bus, device, function and dword fields. It also checks, one cycle after each read, whether the read was answered locally or forwarded. The reset request is reached with a one-byte offset-1 write. The bench then reads the latch back to prove it was not disturbed.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned LEN_W   = 3;
  localparam int unsigned LANE_W  = 2;
  localparam int unsigned EN_BIT  = DATA_W - 1;
  localparam int unsigned RST_BIT = 2;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] off,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] latch_q,
  output logic              rst_pulse_q
);
  logic [4:0]        lane_sh;
  logic [DATA_W-1:0] mask;
  logic              size_ok;
  logic              fits;
  logic              is_rst;
  logic              upd;
  logic [DATA_W-1:0] latch_d;

  always_comb begin
    lane_sh = {off, 3'b000};
    size_ok = 1'b1;
    case (len)
      3'd1:    mask = 32'h0000_00FF << lane_sh;
      3'd2:    mask = 32'h0000_FFFF << lane_sh;
      3'd4:    mask = 32'hFFFF_FFFF;
      default: begin
        mask    = '0;
        size_ok = 1'b0;
      end
    endcase
    fits    = ({2'b00, off} + {1'b0, len}) <= 4'd4;
    is_rst  = wr_en && (off == 2'd1) && (len == 3'd1) && wdata[RST_BIT];
    upd     = wr_en && size_ok && fits && !is_rst;
    latch_d = (latch_q & ~mask) | ((wdata << lane_sh) & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q     <= '0;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= is_rst;
      if (upd) latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/cfg_read_shaper.sv
module cfg_read_shaper
  import cfg_port_pkg::*;
(
  input  logic [DATA_W-1:0] val,
  input  logic [LANE_W-1:0] start,
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] data
);
  logic              ovf;
  logic [DATA_W-1:0] shifted;

  assign ovf     = ({2'b00, start} + {1'b0, len}) > 4'd4;
  assign shifted = val >> {start, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data[g*8 +: 8] = ovf ? 8'hFF :
                            (len > LEN_W'(g)) ? shifted[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/cfg_fwd.sv
module cfg_fwd
  import cfg_port_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned REG_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_go,
  input  logic                           wr_go,
  input  logic [BUS_W+DEV_W+FN_W+REG_W-1:2] fields,
  input  logic [LANE_W-1:0]              boff,
  input  logic [LEN_W-1:0]               len,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           cfg_rvalid,
  output logic                           cfg_req,
  output logic                           cfg_we,
  output logic [BUS_W-1:0]               cfg_bus,
  output logic [DEV_W-1:0]               cfg_dev,
  output logic [FN_W-1:0]                cfg_fn,
  output logic [REG_W-3:0]               cfg_reg,
  output logic [LANE_W-1:0]              cfg_boff,
  output logic [LEN_W-1:0]               cfg_len,
  output logic [DATA_W-1:0]              cfg_wdata,
  output logic                           resp_fire,
  output logic [LANE_W-1:0]              pend_start,
  output logic [LEN_W-1:0]               pend_len
);
  localparam int unsigned FIELD_W = BUS_W + DEV_W + FN_W + REG_W;
  localparam int unsigned FN_LSB  = REG_W;
  localparam int unsigned DEV_LSB = FN_LSB + FN_W;
  localparam int unsigned BUS_LSB = DEV_LSB + DEV_W;

  logic [FIELD_W-1:2] fld_q;
  logic               req_d, load, pend_q, pend_d;

  always_comb begin
    req_d  = rd_go | wr_go;
    load   = req_d;
    pend_d = pend_q;
    if (rd_go)                    pend_d = 1'b1;
    else if (pend_q && cfg_rvalid) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_req    <= 1'b0;
      cfg_we     <= 1'b0;
      pend_q     <= 1'b0;
      fld_q      <= '0;
      cfg_boff   <= '0;
      cfg_len    <= '0;
      cfg_wdata  <= '0;
      pend_start <= '0;
      pend_len   <= '0;
    end else begin
      cfg_req <= req_d;
      pend_q  <= pend_d;
      if (load) begin
        cfg_we    <= wr_go;
        fld_q     <= fields;
        cfg_boff  <= boff;
        cfg_len   <= len;
        cfg_wdata <= wdata;
      end
      if (rd_go) begin
        pend_start <= boff;
        pend_len   <= len;
      end
    end
  end

  assign cfg_bus   = fld_q[BUS_LSB +: BUS_W];
  assign cfg_dev   = fld_q[DEV_LSB +: DEV_W];
  assign cfg_fn    = fld_q[FN_LSB +: FN_W];
  assign cfg_reg   = fld_q[REG_W-1:2];
  assign resp_fire = pend_q && cfg_rvalid;
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter int unsigned OFF_W = 4,
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned REG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [2:0]        host_len,
  input  logic [31:0]       host_wdata,
  output logic              host_rvalid,
  output logic [31:0]       host_rdata,
  output logic              rst_req,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [BUS_W-1:0]  cfg_bus,
  output logic [DEV_W-1:0]  cfg_dev,
  output logic [FN_W-1:0]   cfg_fn,
  output logic [REG_W-3:0]  cfg_reg,
  output logic [1:0]        cfg_boff,
  output logic [2:0]        cfg_len,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_rvalid,
  input  logic [31:0]       cfg_rdata
);
  localparam int unsigned FIELD_W = BUS_W + DEV_W + FN_W + REG_W;

  logic [DATA_W-1:0] latch_q;
  logic              latch_sel, data_sel, en, ovf;
  logic              rd, fwd_rd, fwd_wr, local_rd, latch_wr;
  logic              resp_fire;
  logic [LANE_W-1:0] pend_start, sh_start;
  logic [LEN_W-1:0]  pend_len, sh_len;
  logic [DATA_W-1:0] sh_val, sh_data;
  logic              rvalid_d;
  logic              spare_unused;

  assign spare_unused = ^{latch_q[EN_BIT-1:FIELD_W], latch_q[1:0]};

  always_comb begin
    latch_sel = host_off[OFF_W-1:2] == '0;
    data_sel  = host_off[OFF_W-1:2] == (OFF_W-2)'(1);
    en        = latch_q[EN_BIT];
    ovf       = ({2'b00, host_off[1:0]} + {1'b0, host_len}) > 4'd4;
    rd        = host_req && !host_we;
    fwd_rd    = rd && data_sel && en && !ovf;
    local_rd  = rd && !fwd_rd;
    fwd_wr    = host_req && host_we && data_sel && en;
    latch_wr  = host_req && host_we && latch_sel;
    if (local_rd) begin
      sh_val   = latch_sel ? latch_q : ALL_ONES;
      sh_start = host_off[1:0];
      sh_len   = host_len;
    end else begin
      sh_val   = cfg_rdata;
      sh_start = pend_start;
      sh_len   = pend_len;
    end
    rvalid_d = local_rd | resp_fire;
  end

  cfg_addr_latch i_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (latch_wr),
    .off         (host_off[1:0]),
    .len         (host_len),
    .wdata       (host_wdata),
    .latch_q     (latch_q),
    .rst_pulse_q (rst_req)
  );

  cfg_read_shaper i_shaper (
    .val   (sh_val),
    .start (sh_start),
    .len   (sh_len),
    .data  (sh_data)
  );

  cfg_fwd #(
    .BUS_W (BUS_W),
    .DEV_W (DEV_W),
    .FN_W  (FN_W),
    .REG_W (REG_W)
  ) i_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_go      (fwd_rd),
    .wr_go      (fwd_wr),
    .fields     (latch_q[FIELD_W-1:2]),
    .boff       (host_off[1:0]),
    .len        (host_len),
    .wdata      (host_wdata),
    .cfg_rvalid (cfg_rvalid),
    .cfg_req    (cfg_req),
    .cfg_we     (cfg_we),
    .cfg_bus    (cfg_bus),
    .cfg_dev    (cfg_dev),
    .cfg_fn     (cfg_fn),
    .cfg_reg    (cfg_reg),
    .cfg_boff   (cfg_boff),
    .cfg_len    (cfg_len),
    .cfg_wdata  (cfg_wdata),
    .resp_fire  (resp_fire),
    .pend_start (pend_start),
    .pend_len   (pend_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rvalid_d;
      if (rvalid_d) host_rdata <= sh_data;
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int unsigned OFF_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             host_we,
  input logic [OFF_W-1:0] host_off,
  input logic [2:0]       host_len,
  input logic [31:0]      host_wdata,
  input logic             host_rvalid,
  input logic             rst_req,
  input logic             cfg_req,
  input logic [31:0]      latch_q
);
  // R5
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5
  rst_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_off == OFF_W'(1) && host_len == 3'd1 && host_wdata[2])
    |=> (rst_req && $stable(latch_q)));

  // R6
  fwd_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> latch_q[31]);

  // R11
  rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);

  // R2
  far_read_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && (host_off >> 3) != '0) |=> (host_rvalid && !cfg_req));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && host_we) |=> $stable(latch_q));

  // R3
  latch_wr_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && (host_off >> 2) == '0) |=> !cfg_req);
endmodule

bind cfg_port_decoder cfg_port_chk #(.OFF_W(OFF_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_req    (host_req),
  .host_we     (host_we),
  .host_off    (host_off),
  .host_len    (host_len),
  .host_wdata  (host_wdata),
  .host_rvalid (host_rvalid),
  .rst_req     (rst_req),
  .cfg_req     (cfg_req),
  .latch_q     (latch_q)
);

// File: tb/test_cfg_port_decoder.sv
module test_cfg_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [3:0]  host_off;
  logic [2:0]  host_len;
  logic [31:0] host_wdata;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        rst_req, cfg_req, cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [1:0]  cfg_boff;
  logic [2:0]  cfg_len;
  logic [31:0] cfg_wdata;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;

  int n_cmp = 0, n_bad = 0, exp_rst = 0, n_cfg_rd = 0, n_cfg_wr = 0;
  bit done = 0;
  logic [31:0] rd_q[$];
  string       rd_t[$];
  logic [63:0] wr_q[$];
  string       wr_t[$];

  always #5 clk = ~clk;

  cfg_port_decoder i_cfg_port_decoder (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl(input logic [7:0] b, input logic [4:0] d,
                                      input logic [2:0] f, input logic [5:0] r);
    return {8'hA5, b, d, f, 2'b00, r};
  endfunction

  function automatic logic [63:0] wpk(input logic [7:0] b, input logic [4:0] d,
      input logic [2:0] f, input logic [5:0] r, input logic [1:0] bo,
      input logic [2:0] l, input logic [31:0] w);
    return {5'b0, b, d, f, r, bo, l, w};
  endfunction

  // downstream model: answers a read one cycle after its request
  initial begin
    cfg_rvalid = 1'b0;
    cfg_rdata  = '0;
    forever begin
      @(negedge clk);
      if (cfg_req && !cfg_we) begin
        n_cfg_rd++;
        cfg_rvalid = 1'b1;
        cfg_rdata  = mdl(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
      end else begin
        cfg_rvalid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (host_rvalid) begin
          if (rd_q.size() == 0) check("R11 unexpected response", 64'(host_rdata), 64'hX);
          else check(rd_t.pop_front(), 64'(host_rdata), 64'(rd_q.pop_front()));
        end
        if (cfg_req && cfg_we) begin
          n_cfg_wr++;
          if (wr_q.size() == 0) check("R6 unexpected cfg write", 64'(cfg_wdata), 64'hX);
          else check(wr_t.pop_front(),
                     wpk(cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_boff, cfg_len, cfg_wdata),
                     wr_q.pop_front());
        end
        if (rst_req) begin
          if (exp_rst > 0) exp_rst--;
          else check("R5 unexpected rst_req", 64'd1, 64'd0);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] off, input logic [2:0] len, input logic [31:0] exp,
                    input bit fwd, input string tag);
    rd_q.push_back(exp);
    rd_t.push_back(tag);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_off = off; host_len = len; host_wdata = '0;
    @(negedge clk);
    host_req = 1'b0;
    // R11: local answers now, forwarded shows cfg_req now and answers next cycle
    check({"R11 timing ", tag}, {62'b0, cfg_req, host_rvalid}, fwd ? 64'd2 : 64'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] off, input logic [2:0] len, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_off = off; host_len = len; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int wr_before, rd_before;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_off = '0; host_len = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle outputs", {61'b0, host_rvalid, rst_req, cfg_req}, 64'd0);
    rd(4'd0, 3'd4, 32'h0000_0000, 0, "R1 latch reset");
    rd(4'd4, 3'd4, 32'hFFFF_FFFF, 0, "R1 window disabled");

    wr(4'd0, 3'd4, 32'h1122_3344);
    rd(4'd0, 3'd4, 32'h1122_3344, 0, "R3 full write");
    wr(4'd2, 3'd2, 32'h0000_55AA);
    rd(4'd0, 3'd4, 32'h55AA_3344, 0, "R3 two-byte merge");

    wr(4'd0, 3'd3, 32'hFFFF_FFFF);
    wr(4'd2, 3'd4, 32'hFFFF_FFFF);
    wr(4'd3, 3'd2, 32'hFFFF_FFFF);
    rd(4'd0, 3'd4, 32'h55AA_3344, 0, "R4 bad writes ignored");

    exp_rst++;
    wr(4'd1, 3'd1, 32'h0000_0004);
    rd(4'd0, 3'd4, 32'h55AA_3344, 0, "R5 latch kept on reset request");
    check("R5 reset pulse seen", 64'(exp_rst), 64'd0);
    wr(4'd1, 3'd1, 32'h0000_007B);
    rd(4'd0, 3'd4, 32'h55AA_7B44, 0, "R3 byte1 without bit2");
    wr(4'd0, 3'd1, 32'h0000_0099);
    rd(4'd1, 3'd2, 32'h0000_AA7B, 0, "R7 lanes 1-2");
    rd(4'd3, 3'd1, 32'h0000_0055, 0, "R7 lane 3");
    rd(4'd0, 3'd1, 32'h0000_0099, 0, "R7 lane 0");
    rd(4'd2, 3'd3, 32'hFFFF_FFFF, 0, "R8 latch read overflow");

    wr(4'd0, 3'd4, 32'h8012_AB5C);
    rd(4'd4, 3'd4, mdl(8'h12, 5'h15, 3'd3, 6'h17), 1, "R9 forwarded fields");
    rd(4'd6, 3'd2, {16'h0, mdl(8'h12, 5'h15, 3'd3, 6'h17) >> 16}, 1, "R7 forwarded lanes 2-3");
    rd(4'd7, 3'd1, {24'h0, mdl(8'h12, 5'h15, 3'd3, 6'h17) >> 24}, 1, "R7 forwarded lane 3");
    rd_before = n_cfg_rd;
    rd(4'd5, 3'd4, 32'hFFFF_FFFF, 0, "R8 window overflow");
    check("R8 no downstream read", 64'(n_cfg_rd), 64'(rd_before));
    rd(4'd0, 3'd4, 32'h8012_AB5C, 0, "R3 enabled latch readback");
    wr_q.push_back(wpk(8'h12, 5'h15, 3'd3, 6'h17, 2'd2, 3'd2, 32'h0000_BEEF));
    wr_t.push_back("R10 write boff2 len2");
    wr(4'd6, 3'd2, 32'h0000_BEEF);
    wr_q.push_back(wpk(8'h12, 5'h15, 3'd3, 6'h17, 2'd0, 3'd4, 32'hCAFE_F00D));
    wr_t.push_back("R10 write boff0 len4");
    wr(4'd4, 3'd4, 32'hCAFE_F00D);
    check("R10 two writes forwarded", 64'(n_cfg_wr), 64'd2);

    wr(4'd3, 3'd1, 32'h0000_0000);
    rd(4'd0, 3'd4, 32'h0012_AB5C, 0, "R3 top byte cleared");
    wr_before = n_cfg_wr;
    wr(4'd4, 3'd4, 32'h1234_5678);
    check("R6 disabled write dropped", 64'(n_cfg_wr), 64'(wr_before));
    rd(4'd4, 3'd4, 32'hFFFF_FFFF, 0, "R6 disabled read");
    rd(4'd7, 3'd1, 32'h0000_00FF, 0, "R6 disabled byte read");

    rd(4'd8, 3'd4, 32'hFFFF_FFFF, 0, "R2 far read");
    rd(4'd9, 3'd1, 32'h0000_00FF, 0, "R2 far byte read");
    wr(4'd12, 3'd4, 32'h0000_0000);
    wr(4'd9, 3'd1, 32'h0000_0004);
    rd(4'd0, 3'd4, 32'h0012_AB5C, 0, "R2 far writes ignored");

    repeat (4) @(negedge clk);
    check("R5 no pending reset pulse", 64'(exp_rst), 64'd0);
    check("R11 all responses seen", 64'(rd_q.size()), 64'd0);
    check("R10 all writes seen", 64'(wr_q.size()), 64'd0);
    done = 1;
    finish_run();
  end
endmodule